// File: doc/BRIEF.md
# Byte-Wide Converter Register Port

This block is the host-facing register port of a data converter. A host reaches it over an 8-bit data path with active-low select, read and write strobes and a byte-lane select line. Every register write is a 16-bit word built from two byte writes. The top two bits of the word name the destination. The lower 14 bits are stored in the control register or the test register, or they are forwarded to the calibration engine.

Reads do not carry an address. The source is picked by two read-select bits that stay in the control register until the host rewrites them. A conversion result comes back as 12 bits in one access. Other sources can be read one byte lane at a time. Calibration words are captured on the low-lane read, so that the later high-lane read returns the matching half of the same word. The converter core, the status logic and the calibration engine sit outside the block, and their data arrives on input ports.

All strobes are sampled on the block clock. An access begins on the first clock edge at which select and the relevant strobe are both low.

Top module: `cnv_host_port`

## Requirements
- R1: After reset, the control register and the test register read as zero, and cal_wr_o, dat_oe_o and dat_o are all low.
- R2: A write access with hben_i low stores dat_i as the low byte of a word. A following write access with hben_i high completes the word as {dat_i, low byte}. Word bits 15:14 = 2'b11 load bits 13:0 into the control register, which takes effect at the clock edge of the high-byte access.
- R3: Word bits 15:14 = 2'b01 load bits 13:0 into the test register. Bits 15:14 = 2'b00 change no register.
- R4: Word bits 15:14 = 2'b10 produce a one-cycle cal_wr_o pulse in the cycle after the high-byte edge, with cal_wdata_o equal to word bits 13:0. The pulse is produced only when control bit 0 (start-calibration) is 0. cal_sel_o always shows control bits 2:1.
- R5: Control bits 13:10 are stored as zero whatever value is written to them.
- R6: A high-byte write with no pending low byte is dropped. Deasserting cs_ni discards a pending low byte.
- R7: With control bits 7:6 = 00, a read with hben_i low returns {conv_result_i}. A read with hben_i high returns {8'b0, conv_result_i[11:8]}.
- R8: With control bits 7:6 = 01 (test register, read as {2'b00, test}) or 11 (status_i), a read with hben_i low returns word bits 11:0, and a read with hben_i high returns {4'b0, word bits 15:8}.
- R9: With control bits 7:6 = 10, a read with hben_i low returns {4'b0, cal_rdata_i[7:0]} and captures cal_rdata_i. A read with hben_i high returns {4'b0, captured bits 15:8}.
- R10: dat_oe_o is high only while cs_ni and rd_ni are both low. While dat_oe_o is low, dat_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| hben_i | input | 1 | Byte-lane select: 1 = high byte |
| dat_i | input | 8 | Write data byte |
| dat_o | output | 12 | Read data |
| dat_oe_o | output | 1 | Read data drive enable |
| conv_result_i | input | 12 | Latest conversion result |
| status_i | input | 16 | Status word |
| cal_rdata_i | input | 16 | Calibration word at cal_sel_o |
| ctrl_o | output | 14 | Control register |
| test_o | output | 14 | Test register |
| cal_sel_o | output | 2 | Calibration register pointer |
| cal_wr_o | output | 1 | Calibration write pulse |
| cal_wdata_o | output | 14 | Calibration write data |

## Verification
The bench builds the block with its default parameters: an 8-bit byte lane, a 14-bit payload, a 12-bit result and reserved control bits from 10 upward. With these values every destination code and every read source can be reached with a few dozen accesses. The all-ones control write exposes the reserved-bit clearing, and the calibration snapshot can be told apart from the live calibration input by changing that input between the two byte reads.

// File: rtl/cnv_port_pkg.sv
package cnv_port_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned WORD_W  = 2 * BYTE_W;
  localparam int unsigned PAY_W   = 14;
  localparam int unsigned RES_W   = 12;
  localparam int unsigned BUS_W   = 12;
  localparam int unsigned RSV_LO  = 10;
  // control field positions decoded by neighbours
  localparam int unsigned CF_STCAL = 0;
  localparam int unsigned CF_CSEL  = 1;
  localparam int unsigned CF_RSEL  = 6;

  typedef enum logic [1:0] {
    DST_NONE = 2'b00,
    DST_TEST = 2'b01,
    DST_CAL  = 2'b10,
    DST_CTRL = 2'b11
  } dst_e;

  typedef enum logic [1:0] {
    SRC_CONV = 2'b00,
    SRC_TEST = 2'b01,
    SRC_CAL  = 2'b10,
    SRC_STAT = 2'b11
  } src_e;
endpackage

// File: rtl/cnv_byte_pair.sv
module cnv_byte_pair #(
  parameter int unsigned BYTE_W = cnv_port_pkg::BYTE_W,
  localparam int unsigned WORD_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic              hben_i,
  input  logic [BYTE_W-1:0] dat_i,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);
  logic              wr_act, wr_act_q, wr_stb, pend_q;
  logic [BYTE_W-1:0] lo_q;

  assign wr_act = ~cs_ni & ~wr_ni;
  assign wr_stb = wr_act & ~wr_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_act_q <= 1'b0;
      pend_q   <= 1'b0;
      lo_q     <= '0;
    end else begin
      wr_act_q <= wr_act;
      if (cs_ni) begin
        pend_q <= 1'b0;
      end else if (wr_stb) begin
        if (!hben_i) begin
          lo_q   <= dat_i;
          pend_q <= 1'b1;
        end else begin
          pend_q <= 1'b0;
        end
      end
    end
  end

  // orphan high byte never completes a word
  assign word_vld_o = wr_stb & hben_i & pend_q;
  assign word_o     = {dat_i, lo_q};
endmodule

// File: rtl/cnv_reg_bank.sv
module cnv_reg_bank
  import cnv_port_pkg::*;
#(
  parameter int unsigned WORD_W = cnv_port_pkg::WORD_W,
  parameter int unsigned PAY_W  = cnv_port_pkg::PAY_W,
  parameter int unsigned RSV_LO = cnv_port_pkg::RSV_LO
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             word_vld_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [PAY_W-1:0] ctrl_o,
  output logic [PAY_W-1:0] test_o,
  output logic [1:0]       cal_sel_o,
  output logic             cal_wr_o,
  output logic [PAY_W-1:0] cal_wdata_o
);
  dst_e             dst;
  logic [PAY_W-1:0] pay, ctrl_d;
  logic [PAY_W-1:0] ctrl_q, test_q, cal_wdata_q;
  logic             cal_wr_q;

  assign dst = dst_e'(word_i[WORD_W-1 -: 2]);
  assign pay = word_i[PAY_W-1:0];

  always_comb begin
    ctrl_d = pay;
    ctrl_d[PAY_W-1:RSV_LO] = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= '0;
      test_q      <= '0;
      cal_wr_q    <= 1'b0;
      cal_wdata_q <= '0;
    end else begin
      cal_wr_q <= 1'b0;
      if (word_vld_i) begin
        unique case (dst)
          DST_CTRL: ctrl_q <= ctrl_d;
          DST_TEST: test_q <= pay;
          DST_CAL: begin
            // pointer only valid while no calibration is requested
            cal_wr_q    <= ~ctrl_q[CF_STCAL];
            cal_wdata_q <= pay;
          end
          default: ;
        endcase
      end
    end
  end

  assign ctrl_o      = ctrl_q;
  assign test_o      = test_q;
  assign cal_sel_o   = ctrl_q[CF_CSEL +: 2];
  assign cal_wr_o    = cal_wr_q;
  assign cal_wdata_o = cal_wdata_q;
endmodule

// File: rtl/cnv_read_mux.sv
module cnv_read_mux
  import cnv_port_pkg::*;
#(
  parameter int unsigned BYTE_W = cnv_port_pkg::BYTE_W,
  parameter int unsigned PAY_W  = cnv_port_pkg::PAY_W,
  parameter int unsigned RES_W  = cnv_port_pkg::RES_W,
  parameter int unsigned BUS_W  = cnv_port_pkg::BUS_W,
  localparam int unsigned WORD_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              hben_i,
  input  logic [1:0]        src_i,
  input  logic [RES_W-1:0]  conv_result_i,
  input  logic [PAY_W-1:0]  test_i,
  input  logic [WORD_W-1:0] status_i,
  input  logic [WORD_W-1:0] cal_rdata_i,
  output logic [BUS_W-1:0]  dat_o,
  output logic              dat_oe_o
);
  src_e              src;
  logic              rd_act, rd_act_q, rd_stb;
  logic [WORD_W-1:0] word, snap_q;

  assign src    = src_e'(src_i);
  assign rd_act = ~cs_ni & ~rd_ni;
  assign rd_stb = rd_act & ~rd_act_q;

  always_comb begin
    unique case (src)
      SRC_CONV: word = WORD_W'(conv_result_i);
      SRC_TEST: word = WORD_W'(test_i);
      SRC_CAL:  word = cal_rdata_i;
      default:  word = status_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_act_q <= 1'b0;
      snap_q   <= '0;
    end else begin
      rd_act_q <= rd_act;
      if (rd_stb && !hben_i && src == SRC_CAL) snap_q <= cal_rdata_i;
    end
  end

  always_comb begin
    if (!rd_act) begin
      dat_o = '0;
    end else if (hben_i) begin
      dat_o = (src == SRC_CAL) ? BUS_W'(snap_q[WORD_W-1 -: BYTE_W])
                               : BUS_W'(word[WORD_W-1 -: BYTE_W]);
    end else begin
      dat_o = (src == SRC_CAL) ? BUS_W'(cal_rdata_i[BYTE_W-1:0])
                               : word[BUS_W-1:0];
    end
  end

  assign dat_oe_o = rd_act;
endmodule

// File: rtl/cnv_host_port.sv
module cnv_host_port
  import cnv_port_pkg::*;
#(
  parameter int unsigned P_BYTE_W = cnv_port_pkg::BYTE_W,
  parameter int unsigned P_PAY_W  = cnv_port_pkg::PAY_W,
  parameter int unsigned P_RES_W  = cnv_port_pkg::RES_W,
  parameter int unsigned P_BUS_W  = cnv_port_pkg::BUS_W,
  parameter int unsigned P_RSV_LO = cnv_port_pkg::RSV_LO,
  localparam int unsigned P_WORD_W = 2 * P_BYTE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_ni,
  input  logic                rd_ni,
  input  logic                wr_ni,
  input  logic                hben_i,
  input  logic [P_BYTE_W-1:0] dat_i,
  output logic [P_BUS_W-1:0]  dat_o,
  output logic                dat_oe_o,
  input  logic [P_RES_W-1:0]  conv_result_i,
  input  logic [P_WORD_W-1:0] status_i,
  input  logic [P_WORD_W-1:0] cal_rdata_i,
  output logic [P_PAY_W-1:0]  ctrl_o,
  output logic [P_PAY_W-1:0]  test_o,
  output logic [1:0]          cal_sel_o,
  output logic                cal_wr_o,
  output logic [P_PAY_W-1:0]  cal_wdata_o
);
  logic                word_vld;
  logic [P_WORD_W-1:0] word;

  cnv_byte_pair #(.BYTE_W(P_BYTE_W)) u_pair (
    .clk_i, .rst_ni, .cs_ni, .wr_ni, .hben_i, .dat_i,
    .word_vld_o(word_vld), .word_o(word)
  );

  cnv_reg_bank #(.WORD_W(P_WORD_W), .PAY_W(P_PAY_W), .RSV_LO(P_RSV_LO)) u_bank (
    .clk_i, .rst_ni, .word_vld_i(word_vld), .word_i(word),
    .ctrl_o, .test_o, .cal_sel_o, .cal_wr_o, .cal_wdata_o
  );

  cnv_read_mux #(
    .BYTE_W(P_BYTE_W), .PAY_W(P_PAY_W), .RES_W(P_RES_W), .BUS_W(P_BUS_W)
  ) u_rmux (
    .clk_i, .rst_ni, .cs_ni, .rd_ni, .hben_i,
    .src_i(ctrl_o[CF_RSEL +: 2]),
    .conv_result_i, .test_i(test_o), .status_i, .cal_rdata_i,
    .dat_o, .dat_oe_o
  );
endmodule

// File: rtl/cnv_host_port_chk.sv
module cnv_host_port_chk #(
  parameter int unsigned P_PAY_W = 14,
  parameter int unsigned P_RES_W = 12,
  parameter int unsigned P_BUS_W = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cs_ni,
  input logic               rd_ni,
  input logic               wr_ni,
  input logic               hben_i,
  input logic [P_BUS_W-1:0] dat_o,
  input logic               dat_oe_o,
  input logic [P_RES_W-1:0] conv_result_i,
  input logic [P_PAY_W-1:0] ctrl_o,
  input logic [P_PAY_W-1:0] test_o,
  input logic               cal_wr_o
);
  p_ctrl_on_hi_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_o) |-> $past(!cs_ni && !wr_ni && hben_i));

  p_idle_keeps_regs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> ($stable(ctrl_o) && $stable(test_o)));

  p_calwr_gated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_wr_o |-> $past(!cs_ni && !wr_ni && hben_i && !ctrl_o[0]));

  p_calwr_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_wr_o |=> !cal_wr_o);

  p_bus_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dat_oe_o |-> (dat_o == '0));

  p_conv_full_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_oe_o && ctrl_o[7:6] == 2'b00 && !hben_i) |-> (dat_o == P_BUS_W'(conv_result_i)));
endmodule

bind cnv_host_port cnv_host_port_chk #(
  .P_PAY_W(P_PAY_W), .P_RES_W(P_RES_W), .P_BUS_W(P_BUS_W)
) u_chk (
  .clk_i, .rst_ni, .cs_ni, .rd_ni, .wr_ni, .hben_i, .dat_o, .dat_oe_o,
  .conv_result_i, .ctrl_o, .test_o, .cal_wr_o
);

// File: tb/cnv_host_port_tb_top.sv
module cnv_host_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, hben = 1'b0;
  logic [7:0]  din = '0;
  logic [11:0] dout;
  logic        doe;
  logic [11:0] conv = '0;
  logic [15:0] stat = '0, cal_rd = '0;
  logic [13:0] ctrl, test, cal_wd;
  logic [1:0]  cal_sel;
  logic        cal_wr;

  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;
  logic        seen_wr;
  logic [13:0] seen_wd;

  always #4 clk = ~clk;

  cnv_host_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .hben_i(hben), .dat_i(din), .dat_o(dout), .dat_oe_o(doe),
    .conv_result_i(conv), .status_i(stat), .cal_rdata_i(cal_rd),
    .ctrl_o(ctrl), .test_o(test), .cal_sel_o(cal_sel), .cal_wr_o(cal_wr),
    .cal_wdata_o(cal_wd)
  );

  // {word, expected ctrl, expected test}
  localparam logic [43:0] VEC [8] = '{
    {16'hC040, 14'h0040, 14'h0000},
    {16'h4ABC, 14'h0040, 14'h0ABC},
    {16'h0123, 14'h0040, 14'h0ABC},
    {16'hFFFF, 14'h03FF, 14'h0ABC},
    {16'h7FFF, 14'h03FF, 14'h3FFF},
    {16'hC0C6, 14'h00C6, 14'h3FFF},
    {16'h4000, 14'h00C6, 14'h0000},
    {16'hC000, 14'h0000, 14'h0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_byte(input logic hb, input logic [7:0] b);
    @(negedge clk); wr_n = 1'b0; hben = hb; din = b;
    @(negedge clk); seen_wr = cal_wr; seen_wd = cal_wd; wr_n = 1'b1;
  endtask

  task automatic wr_word(input logic [15:0] w);
    @(negedge clk); cs_n = 1'b0;
    wr_byte(1'b0, w[7:0]);
    wr_byte(1'b1, w[15:8]);
    @(negedge clk); cs_n = 1'b1;
  endtask

  task automatic rd_acc(input logic hb, output logic [11:0] d, output logic oe);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; hben = hb;
    @(negedge clk); d = dout; oe = doe;
    rd_n = 1'b1; cs_n = 1'b1;
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [11:0] d;
    logic        oe;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ctrl", ctrl, 0);
    chk("R1 test", test, 0);
    chk("R1 oe", doe, 0);
    chk("R1 dat", dout, 0);
    chk("R1 calwr", cal_wr, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R5 table walk
    for (int i = 0; i < 8; i++) begin
      wr_word(VEC[i][43:28]);
      chk("R2 R3 R5 ctrl", ctrl, VEC[i][27:14]);
      chk("R2 R3 R5 test", test, VEC[i][13:0]);
    end

    // R6 orphan high byte
    @(negedge clk); cs_n = 1'b0;
    wr_byte(1'b1, 8'hC0);
    @(negedge clk); cs_n = 1'b1;
    chk("R6 orphan", ctrl, 0);
    // R6 pending cleared by deselect
    @(negedge clk); cs_n = 1'b0;
    wr_byte(1'b0, 8'h55);
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk); cs_n = 1'b0;
    wr_byte(1'b1, 8'hC0);
    @(negedge clk); cs_n = 1'b1;
    chk("R6 deselect", ctrl, 0);

    // R7 conversion result
    conv = 12'hA5C;
    rd_acc(1'b0, d, oe);
    chk("R7 full", d, 12'hA5C);
    chk("R10 oe read", oe, 1);
    rd_acc(1'b1, d, oe);
    chk("R7 upper", d, 12'h00A);

    // R8 test and status sources
    wr_word(16'h5234);
    wr_word(16'hC040);
    rd_acc(1'b0, d, oe); chk("R8 test lo", d, 12'h234);
    rd_acc(1'b1, d, oe); chk("R8 test hi", d, 12'h012);
    stat = 16'hBEEF;
    wr_word(16'hC0C0);
    rd_acc(1'b0, d, oe); chk("R8 stat lo", d, 12'hEEF);
    rd_acc(1'b1, d, oe); chk("R8 stat hi", d, 12'h0BE);

    // R4 calibration write path
    wr_word(16'hC082);
    chk("R4 pointer", cal_sel, 2'b01);
    wr_word(16'h8123);
    chk("R4 pulse", seen_wr, 1);
    chk("R4 data", seen_wd, 14'h0123);
    @(negedge clk);
    chk("R4 one cycle", cal_wr, 0);
    wr_word(16'hC083);
    wr_word(16'h8FFF);
    chk("R4 blocked", seen_wr, 0);

    // R9 calibration read with snapshot
    wr_word(16'hC082);
    cal_rd = 16'h9A7E;
    rd_acc(1'b0, d, oe); chk("R9 lo", d, 12'h07E);
    cal_rd = 16'h1111;
    rd_acc(1'b1, d, oe); chk("R9 hi snapshot", d, 12'h09A);

    // R10 drive enable
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b1;
    @(negedge clk); chk("R10 cs only", doe, 0); chk("R10 dat", dout, 0);
    cs_n = 1'b1; rd_n = 1'b0;
    @(negedge clk); chk("R10 rd only", doe, 0);
    rd_n = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule